// File: doc/BRIEF.md
# PHY Management Register Front End

This block holds a small model of an Ethernet PHY's management register space together with the MAC-side command registers that reach it. Sixteen 16-bit PHY registers sit behind a single responding PHY address. The host sees five word-wide registers and selects one with `host_sel`: a target address, a command, a write-data holding register, a read-data result and a link-fail status bit. Host writes are single-cycle strobes. Host reads are a combinational multiplex over `host_sel`. The serial management waveform, clock division and auto-negotiation are not modelled.

A PHY register write starts in one of two ways. The host can set the write bit in the command register, or it can write the write-data register while the addressed PHY is the responding one. A read command copies the selected PHY register into the read-data register, or all ones if the PHY address does not respond. The `link_up` input controls the link bit in the PHY status register and the link-partner ability bits. It also sets the host-side link-fail bit, either when a read command samples it or continuously while scanning is enabled. Writing the PHY control register with its top bit set restores every PHY register to its reset value instead of storing the word.

Top module: `mgmt_phy_front`

## Requirements
- R1: After reset the PHY registers hold: index 0 (control) 0x1000, index 1 (status) 0x7848, index 2 0x2000, index 3 0x5C90, index 4 0x01E1, and 0 in every other index, including index 5 (link-partner ability).
- R2: A change on `link_up` takes effect at the next rising clock edge. Link up sets status bit 2 and ORs 0x01E1 into index 5. Link down clears status bit 2 and ANDs index 5 with 0x01FF, so bits 8:0 remain.
- R3: A PHY write of a word with bit 15 set to index 0 restores all sixteen PHY registers to their R1 values and then applies the current `link_up` level as in R2. The written word itself is not stored.
- R4: PHY writes to indices 1, 2 and 3 are ignored. Writes to any other index from 0 to 15 store the word. Register addresses 16 to 31 ignore writes, and a read of one returns 0.
- R5: Host select codes are: 0 address, 1 command, 2 write data, 3 read data, 4 link-fail status. Other codes read 0 and ignore writes. The address register keeps the PHY address in bits 4:0 and the register address in bits 12:8 and reads back in the same positions. The command register keeps bits 2:0.
- R6: A command write with bit 2 set writes the write-data register to the addressed PHY register if the PHY address is 1. Any other PHY address makes it do nothing.
- R7: A command write with bit 1 set loads the read-data register with the addressed PHY register when the PHY address is 1, and with 0xFFFF otherwise. If bits 2 and 1 are set together, the read returns the value after the write.
- R8: A command write with bit 1 set loads the link-fail bit (select 4, bit 0) with the inverse of `link_up`.
- R9: While the stored command bit 0 (scan) is set, each `link_up` change loads the link-fail bit with the inverse of the new level at the same edge. While scan is clear, link changes leave the bit alone.
- R10: A host write to the write-data register stores bits 15:0. When the PHY address is 1, the same cycle writes that word to the addressed PHY register.
- R11: All host registers reset to 0. Host writes to read data (select 3) and link-fail status (select 4) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Current link level from the line side |
| host_we | input | 1 | Single-cycle host write strobe |
| host_sel | input | 3 | Host register select |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Selected host register, combinational |

## Verification
The hardest states to reach are the ones where two paths meet in one cycle. These include a combined write-and-read command whose result must already show the new word, a soft reset issued while the link is up so the link bits are reapplied over the defaults, and a link edge arriving while scan is armed. Directed sequences build each of these. The address register is programmed first, then the write-data register is loaded while pointing at a non-responding PHY so that nothing is committed early, and only then is the command issued. A seeded random mix of host writes and link toggles then runs against a bench model of the whole register space, and the PHY registers are read back through the command path.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned PHY_ADR_W = 5;

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ID_HI = 2;
  localparam int IDX_ID_LO = 3;
  localparam int IDX_ADV = 4;
  localparam int IDX_LPA = 5;

  localparam logic [15:0] STAT_LINK_BIT = 16'h0004;
  localparam logic [15:0] LPA_UP_OR = 16'h01E1;
  localparam logic [15:0] LPA_DN_AND = 16'h01FF;

  typedef enum logic [2:0] {
    SEL_ADDR  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_WDATA = 3'd2,
    SEL_RDATA = 3'd3,
    SEL_STAT  = 3'd4
  } host_sel_e;

  function automatic logic [15:0] reset_value(input int unsigned idx);
    case (idx)
      0: reset_value = 16'h1000;
      1: reset_value = 16'h7848;
      2: reset_value = 16'h2000;
      3: reset_value = 16'h5C90;
      4: reset_value = 16'h01E1;
      default: reset_value = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mgmt_phy_pkg::*;
#(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_up,
  input  logic                 wr_req,
  input  logic [REG_IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [REG_IDX_W-1:0] rd_idx,
  output logic [DW-1:0]        rd_data,
  output logic                 link_chg
);

  localparam int unsigned SW = $clog2(NREGS);

  logic [DW-1:0] regs_q [NREGS];
  logic [DW-1:0] regs_d [NREGS];
  logic [NREGS-1:0] reg_en;
  logic link_q;
  logic wr_in_rng, rd_in_rng, soft_rst, wr_ro;

  assign link_chg  = (link_up != link_q);
  assign wr_in_rng = ((wr_idx >> SW) == '0);
  assign rd_in_rng = ((rd_idx >> SW) == '0);
  assign soft_rst  = wr_req && wr_in_rng && (wr_idx == REG_IDX_W'(IDX_CTRL)) && wr_data[15];
  assign wr_ro     = (wr_idx == REG_IDX_W'(IDX_STAT)) || (wr_idx == REG_IDX_W'(IDX_ID_HI)) ||
                     (wr_idx == REG_IDX_W'(IDX_ID_LO));

  always_comb begin
    for (int i = 0; i < NREGS; i++) regs_d[i] = regs_q[i];
    if (link_chg) begin
      if (link_up) begin
        regs_d[IDX_STAT] = regs_d[IDX_STAT] | STAT_LINK_BIT;
        regs_d[IDX_LPA]  = regs_d[IDX_LPA] | LPA_UP_OR;
      end else begin
        regs_d[IDX_STAT] = regs_d[IDX_STAT] & ~STAT_LINK_BIT;
        regs_d[IDX_LPA]  = regs_d[IDX_LPA] & LPA_DN_AND;
      end
    end
    if (soft_rst) begin
      for (int i = 0; i < NREGS; i++) regs_d[i] = reset_value(i);
      if (link_up) begin
        regs_d[IDX_STAT] = regs_d[IDX_STAT] | STAT_LINK_BIT;
        regs_d[IDX_LPA]  = regs_d[IDX_LPA] | LPA_UP_OR;
      end else begin
        regs_d[IDX_STAT] = regs_d[IDX_STAT] & ~STAT_LINK_BIT;
        regs_d[IDX_LPA]  = regs_d[IDX_LPA] & LPA_DN_AND;
      end
    end else if (wr_req && wr_in_rng && !wr_ro) begin
      regs_d[wr_idx[SW-1:0]] = wr_data;
    end
  end

  // Read path looks through the next state so a combined write+read sees the new word
  assign rd_data = rd_in_rng ? regs_d[rd_idx[SW-1:0]] : '0;

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
      assign reg_en[g] = (regs_d[g] != regs_q[g]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[g] <= reset_value(g);
        else if (reg_en[g]) regs_q[g] <= regs_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else if (link_chg) link_q <= link_up;
  end

endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mgmt_phy_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter logic [PHY_ADR_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 link_up,
  input  logic                 link_chg,
  input  logic                 host_we,
  input  logic [2:0]           host_sel,
  input  logic [31:0]          host_wdata,
  input  logic [DW-1:0]        phy_rd_data,
  output logic                 phy_wr_req,
  output logic [REG_IDX_W-1:0] phy_idx,
  output logic [DW-1:0]        phy_wr_data,
  output logic [PHY_ADR_W-1:0] addr_phy,
  output logic [REG_IDX_W-1:0] addr_reg,
  output logic [2:0]           cmd_q,
  output logic [DW-1:0]        wdata_q,
  output logic [DW-1:0]        rdata_q,
  output logic                 lfail_q
);

  logic sel_addr, sel_cmd, sel_wd, phy_hit, rd_cmd;
  logic en_lf;
  logic [DW-1:0] rdata_d;
  logic unused_hi;

  assign unused_hi = ^host_wdata[31:16];

  assign sel_addr = host_we && (host_sel == SEL_ADDR);
  assign sel_cmd  = host_we && (host_sel == SEL_CMD);
  assign sel_wd   = host_we && (host_sel == SEL_WDATA);
  assign phy_hit  = (addr_phy == PHY_ADDR);
  assign rd_cmd   = sel_cmd && host_wdata[1];

  assign phy_wr_req  = phy_hit && ((sel_cmd && host_wdata[2]) || sel_wd);
  assign phy_wr_data = sel_wd ? host_wdata[DW-1:0] : wdata_q;
  assign phy_idx     = addr_reg;

  assign rdata_d = phy_hit ? phy_rd_data : '1;
  assign en_lf   = rd_cmd || (cmd_q[0] && link_chg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_phy <= '0;
      addr_reg <= '0;
    end else if (sel_addr) begin
      addr_phy <= host_wdata[PHY_ADR_W-1:0];
      addr_reg <= host_wdata[8 +: REG_IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else if (sel_cmd) cmd_q <= host_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdata_q <= '0;
    else if (sel_wd) wdata_q <= host_wdata[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_cmd) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfail_q <= 1'b0;
    else if (en_lf) lfail_q <= !link_up;
  end

endmodule

// File: rtl/mgmt_phy_front.sv
module mgmt_phy_front
  import mgmt_phy_pkg::*;
#(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW = 16,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        host_we,
  input  logic [2:0]  host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);

  logic                 phy_wr_req;
  logic [REG_IDX_W-1:0] phy_idx;
  logic [DW-1:0]        phy_wr_data;
  logic [DW-1:0]        phy_rd_data;
  logic                 link_chg;
  logic [PHY_ADR_W-1:0] addr_phy;
  logic [REG_IDX_W-1:0] addr_reg;
  logic [2:0]           cmd_q;
  logic [DW-1:0]        wdata_q;
  logic [DW-1:0]        rdata_q;
  logic                 lfail_q;

  mgmt_phy_regs #(.NREGS(NREGS), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .wr_req  (phy_wr_req),
    .wr_idx  (phy_idx),
    .wr_data (phy_wr_data),
    .rd_idx  (phy_idx),
    .rd_data (phy_rd_data),
    .link_chg(link_chg)
  );

  mgmt_host_regs #(.DW(DW), .PHY_ADDR(PHY_ADDR)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .link_chg   (link_chg),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .phy_rd_data(phy_rd_data),
    .phy_wr_req (phy_wr_req),
    .phy_idx    (phy_idx),
    .phy_wr_data(phy_wr_data),
    .addr_phy   (addr_phy),
    .addr_reg   (addr_reg),
    .cmd_q      (cmd_q),
    .wdata_q    (wdata_q),
    .rdata_q    (rdata_q),
    .lfail_q    (lfail_q)
  );

  always_comb begin
    case (host_sel)
      SEL_ADDR:  host_rdata = {19'b0, addr_reg, 3'b0, addr_phy};
      SEL_CMD:   host_rdata = {29'b0, cmd_q};
      SEL_WDATA: host_rdata = 32'(wdata_q);
      SEL_RDATA: host_rdata = 32'(rdata_q);
      SEL_STAT:  host_rdata = {31'b0, lfail_q};
      default:   host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mgmt_phy_chk.sv
module mgmt_phy_chk #(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up,
  input logic        host_we,
  input logic [2:0]  host_sel,
  input logic [31:0] host_wdata,
  input logic [4:0]  addr_phy,
  input logic [2:0]  cmd_q,
  input logic [15:0] wdata_q,
  input logic [15:0] rdata_q,
  input logic        lfail_q,
  input logic        link_chg
);

  // R7: non-responding PHY address yields all ones
  p_noresp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 3'd1 && host_wdata[1] && addr_phy != PHY_ADDR) |=> (rdata_q == 16'hFFFF));

  // R8: read command samples the link level into link-fail
  p_read_lf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 3'd1 && host_wdata[1]) |=> (lfail_q == !$past(link_up)));

  // R9: scan tracks link edges
  p_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[0] && link_chg) |=> (lfail_q == !$past(link_up)));

  // R10: write-data register stores the low half-word
  p_wdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_sel == 3'd2) |=> (wdata_q == $past(host_wdata[15:0])));

  // R11: read-only host registers ignore writes
  p_ro_host_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && (host_sel == 3'd3 || host_sel == 3'd4) && !(cmd_q[0] && link_chg))
      |=> ($stable(lfail_q) && $stable(rdata_q)));

  // R5: command register only moves on its own select
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_sel == 3'd1) |=> $stable(cmd_q));

endmodule

bind mgmt_phy_front mgmt_phy_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_up   (link_up),
  .host_we   (host_we),
  .host_sel  (host_sel),
  .host_wdata(host_wdata),
  .addr_phy  (addr_phy),
  .cmd_q     (cmd_q),
  .wdata_q   (wdata_q),
  .rdata_q   (rdata_q),
  .lfail_q   (lfail_q),
  .link_chg  (link_chg)
);

// File: tb/sim_mgmt_phy_front.sv
module sim_mgmt_phy_front;

  logic clk = 1'b0;
  logic rst_n;
  logic link_up;
  logic host_we;
  logic [2:0] host_sel;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_phy [16];
  logic [4:0]  m_ap, m_ar;
  logic [2:0]  m_cmd;
  logic [15:0] m_wd, m_rd;
  logic        m_lf, m_link;

  always #2 clk = ~clk;

  mgmt_phy_front u0 (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [15:0] rst_val(int i);
    case (i)
      0: return 16'h1000;
      1: return 16'h7848;
      2: return 16'h2000;
      3: return 16'h5C90;
      4: return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic void m_apply_link(logic v);
    if (v) begin m_phy[1] = m_phy[1] | 16'h0004; m_phy[5] = m_phy[5] | 16'h01E1; end
    else   begin m_phy[1] = m_phy[1] & ~16'h0004; m_phy[5] = m_phy[5] & 16'h01FF; end
  endfunction

  function automatic void m_reset_phy();
    for (int i = 0; i < 16; i++) m_phy[i] = rst_val(i);
  endfunction

  function automatic void m_phy_write(logic [4:0] idx, logic [15:0] d);
    if (idx < 16) begin
      if (idx == 0 && d[15]) begin m_reset_phy(); m_apply_link(m_link); end
      else if (idx >= 1 && idx <= 3) begin end
      else m_phy[idx[3:0]] = d;
    end
  endfunction

  function automatic void m_host_write(logic [2:0] sel, logic [31:0] d);
    case (sel)
      3'd0: begin m_ap = d[4:0]; m_ar = d[12:8]; end
      3'd1: begin
        if (d[2] && m_ap == 5'd1) m_phy_write(m_ar, m_wd);
        if (d[1]) begin
          m_rd = (m_ap == 5'd1) ? ((m_ar < 16) ? m_phy[m_ar[3:0]] : 16'h0) : 16'hFFFF;
          m_lf = !m_link;
        end
        m_cmd = d[2:0];
      end
      3'd2: begin m_wd = d[15:0]; if (m_ap == 5'd1) m_phy_write(m_ar, d[15:0]); end
      default: begin end
    endcase
  endfunction

  function automatic logic [31:0] m_host_read(logic [2:0] sel);
    case (sel)
      3'd0: return {19'b0, m_ar, 3'b0, m_ap};
      3'd1: return {29'b0, m_cmd};
      3'd2: return {16'b0, m_wd};
      3'd3: return {16'b0, m_rd};
      3'd4: return {31'b0, m_lf};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(posedge clk);
    m_host_write(sel, d);
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    host_we = 1'b0; link_up = v;
    @(posedge clk);
    if (v != m_link) begin
      m_link = v;
      m_apply_link(v);
      if (m_cmd[0]) m_lf = !v;
    end
  endtask

  task automatic hcheck(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_we = 1'b0; host_sel = sel;
    #1;
    chk(host_rdata, exp, tag);
  endtask

  task automatic phy_read(input logic [4:0] ap, input logic [4:0] idx, input logic [15:0] exp,
                          input string tag);
    hwrite(3'd0, {19'b0, idx, 3'b0, ap});
    hwrite(3'd1, 32'd2);
    hcheck(3'd3, {16'b0, exp}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; link_up = 1'b0; host_we = 1'b0; host_sel = 3'd0; host_wdata = '0;
    m_reset_phy(); m_ap = 0; m_ar = 0; m_cmd = 0; m_wd = 0; m_rd = 0; m_lf = 0; m_link = 0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state of host registers
    for (int s = 0; s < 5; s++) begin
      host_sel = 3'(s); #1;
      chk(host_rdata, 32'h0, "R11 reset host reg");
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    phy_read(5'd1, 5'd0, 16'h1000, "R1 ctrl");
    phy_read(5'd1, 5'd1, 16'h7848, "R1 status");
    phy_read(5'd1, 5'd2, 16'h2000, "R1 id hi");
    phy_read(5'd1, 5'd3, 16'h5C90, "R1 id lo");
    phy_read(5'd1, 5'd4, 16'h01E1, "R1 adv");
    phy_read(5'd1, 5'd5, 16'h0000, "R1 lpa");
    phy_read(5'd1, 5'd15, 16'h0000, "R1 idx15");
    // R5 address layout
    hwrite(3'd0, 32'hFFFF_E0E3);
    hcheck(3'd0, 32'h0000_0003, "R5 addr layout");
    hwrite(3'd1, 32'hFFFF_FFF8);
    hcheck(3'd1, 32'h0, "R5 cmd bits");
    hcheck(3'd6, 32'h0, "R5 unused select");

    // R2 link effects
    set_link(1'b1);
    phy_read(5'd1, 5'd1, 16'h784C, "R2 status up");
    phy_read(5'd1, 5'd5, 16'h01E1, "R2 lpa up");
    hcheck(3'd4, 32'h0, "R8 linkfail up");
    set_link(1'b0);
    phy_read(5'd1, 5'd1, 16'h7848, "R2 status down");
    phy_read(5'd1, 5'd5, 16'h01E1, "R2 lpa down keeps low bits");
    hcheck(3'd4, 32'h1, "R8 linkfail down");

    // R4 read-only and range, R10 direct commit
    hwrite(3'd0, {19'b0, 5'd1, 3'b0, 5'd1}); hwrite(3'd2, 32'h0000_1234);
    hwrite(3'd0, {19'b0, 5'd2, 3'b0, 5'd1}); hwrite(3'd2, 32'h0000_1234);
    hwrite(3'd0, {19'b0, 5'd7, 3'b0, 5'd1}); hwrite(3'd2, 32'hABCD_BEEF);
    hcheck(3'd2, 32'h0000_BEEF, "R10 wdata low half");
    hwrite(3'd0, {19'b0, 5'd20, 3'b0, 5'd1}); hwrite(3'd2, 32'h0000_5555);
    phy_read(5'd1, 5'd1, 16'h7848, "R4 status ro");
    phy_read(5'd1, 5'd2, 16'h2000, "R4 id ro");
    phy_read(5'd1, 5'd7, 16'hBEEF, "R10 immediate commit");
    phy_read(5'd1, 5'd20, 16'h0000, "R4 out of range");

    // R10 no commit on other PHY; R7 non-responding
    hwrite(3'd0, {19'b0, 5'd9, 3'b0, 5'd3}); hwrite(3'd2, 32'h0000_C0DE);
    hwrite(3'd1, 32'd2);
    hcheck(3'd3, 32'h0000_FFFF, "R7 other phy all ones");
    phy_read(5'd1, 5'd9, 16'h0000, "R10 no commit other phy");
    // R6 command write, R7 combined write+read
    hwrite(3'd0, {19'b0, 5'd9, 3'b0, 5'd1});
    hwrite(3'd1, 32'd4);
    phy_read(5'd1, 5'd9, 16'hC0DE, "R6 command write");
    hwrite(3'd0, {19'b0, 5'd3, 3'b0, 5'd2}); hwrite(3'd2, 32'h0000_7777);
    hwrite(3'd0, {19'b0, 5'd10, 3'b0, 5'd1});
    hwrite(3'd1, 32'd6);
    hcheck(3'd3, 32'h0000_7777, "R7 write then read same command");
    hwrite(3'd0, {19'b0, 5'd11, 3'b0, 5'd4}); hwrite(3'd1, 32'd4);
    phy_read(5'd1, 5'd11, 16'h0000, "R6 other phy ignored");

    // R3 soft reset with link up
    set_link(1'b1);
    hwrite(3'd0, {19'b0, 5'd4, 3'b0, 5'd1}); hwrite(3'd2, 32'h0000_0011);
    hwrite(3'd0, {19'b0, 5'd0, 3'b0, 5'd1}); hwrite(3'd2, 32'h0000_3100);
    phy_read(5'd1, 5'd0, 16'h3100, "R4 ctrl stores");
    hwrite(3'd0, {19'b0, 5'd0, 3'b0, 5'd1}); hwrite(3'd2, 32'h0000_8000);
    phy_read(5'd1, 5'd0, 16'h1000, "R3 ctrl default");
    phy_read(5'd1, 5'd4, 16'h01E1, "R3 adv default");
    phy_read(5'd1, 5'd7, 16'h0000, "R3 reg7 cleared");
    phy_read(5'd1, 5'd1, 16'h784C, "R3 link reapplied status");
    phy_read(5'd1, 5'd5, 16'h01E1, "R3 link reapplied lpa");

    // R9 scan
    hwrite(3'd1, 32'd1);
    set_link(1'b0);
    hcheck(3'd4, 32'h1, "R9 scan link down");
    set_link(1'b1);
    hcheck(3'd4, 32'h0, "R9 scan link up");
    hwrite(3'd1, 32'd0);
    set_link(1'b0);
    hcheck(3'd4, 32'h0, "R9 no scan no change");

    // R11 read-only host registers
    hwrite(3'd3, 32'h0000_AAAA);
    hwrite(3'd4, 32'h0000_0001);
    hcheck(3'd3, {16'b0, m_rd}, "R11 rdata ignores write");
    hcheck(3'd4, 32'h0, "R11 status ignores write");

    // Random mix against the model
    for (int it = 0; it < 600; it++) begin
      int unsigned op;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      d = $urandom();
      if (op < 2) begin
        d[4:0] = ($urandom_range(0, 3) != 0) ? 5'd1 : d[4:0];
        if ($urandom_range(0, 3) != 0) d[12:8] = {1'b0, d[11:8]};
        hwrite(3'd0, d);
      end else if (op < 4) hwrite(3'd1, d);
      else if (op < 6) begin
        if ($urandom_range(0, 7) != 0) d[15] = 1'b0;
        hwrite(3'd2, d);
      end else if (op < 7) hwrite(3'($urandom_range(3, 7)), d);
      else if (op < 8) set_link(!m_link);
      else begin
        logic [2:0] s;
        s = 3'($urandom_range(0, 4));
        hcheck(s, m_host_read(s), "R5 R7 random host read");
      end
      if (it % 50 == 49) begin
        for (int k = 0; k < 16; k++) phy_read(5'd1, 5'(k), m_phy[k], "R4 R2 random phy sweep");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule